// File: doc/BRIEF.md
# Multi-slot Serial Audio Transmitter

This block turns parallel audio words from a transmit FIFO into a serial bit stream organised in frames of time slots, and drives the frame-sync pin for that stream. It follows an external bit clock. The bit clock pin is oversampled by the system clock. On each shifting edge of the bit clock, the serial data and frame-sync outputs move to the next bit position. Each frame holds a programmable number of slots, each `SLOT_W` bits wide. A per-slot mask selects which slots take a word from the FIFO.

Software sets the framing while the port is stopped. The framing choices are four frame-sync styles (two start one bit early, two start with the data; two last one bit, two last a whole word), frame-sync polarity, bit-clock edge polarity, slot count, word length and the slot mask. When the port starts, the block sends one lead-in bit before the first frame, so that an early frame sync has a bit to sit in. Each word is fetched one bit clock before its slot starts. An active slot that finds the FIFO empty is sent as zeros and raises a sticky underrun flag.

Top module: `tdm_tx`

## Requirements
- R1: A frame has `cfg_slots`+1 slots of `SLOT_W` bits each, with slots 0 to `cfg_slots` sent in order, and frames follow each other without gaps.
- R2: A slot whose bit in `cfg_mask` is 1 carries the next FIFO word. A slot whose mask bit is 0 carries zeros and takes nothing from the FIFO. Mask bits above `cfg_slots` have no effect.
- R3: `cfg_wlen` 0, 1 and 2 select 16, 20 and 24-bit words, and 3 acts as 24. The word is the low bits of `tx_data`, and bits of `tx_data` above the word length are ignored. The word is sent MSB first from the slot's first bit, and the rest of the slot is zero.
- R4: `cfg_fmt` selects the frame-sync shape, using frame bit position p (0 = first bit of slot 0, F-1 = last bit of the frame):
  - 0: asserted at p=F-1 and at p<L-1 with L the word length, and active low.
  - 1: asserted at p<L, and active high.
  - 2: asserted at p=F-1 only, and active high.
  - 3: asserted at p=0 only, and active high.
- R5: `cfg_fs_inv`=1 inverts the `fsync_o` level, both when the sync is asserted and when it is idle.
- R6: With `cfg_bclk_inv`=0, the outputs move to the next bit after a falling edge of `bclk_i`. With `cfg_bclk_inv`=1, they move after a rising edge.
- R7: Configuration is loaded on `cfg_we` only while `en` is low. A write while `en` is high has no effect.
- R8: After `en` rises, the first shifting edge presents a lead-in bit at position F-1 with zero data. Slot 0 of the first frame follows on the next edge.
- R9: `tx_ready` is a one-cycle pulse, issued only while enabled, on the shifting edge that starts the last bit before an active slot. A word is taken when `tx_valid` is also high.
- R10: An active slot that finds `tx_valid` low at its fetch is sent as zeros and sets `underrun_o`. The flag holds until `en` rises again or reset.
- R11: While reset or disabled, `sdata_o` is 0, `tx_ready` is 0 and `fsync_o` sits at its idle level. After reset the idle level is high and `underrun_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Port enable |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_fmt | input | 2 | Frame-sync style |
| cfg_bclk_inv | input | 1 | Shift on rising bit-clock edge when 1 |
| cfg_fs_inv | input | 1 | Invert frame-sync level |
| cfg_slots | input | $clog2(MAX_SLOTS) | Slots per frame minus one |
| cfg_wlen | input | 2 | Word length code |
| cfg_mask | input | MAX_SLOTS | Per-slot active mask |
| tx_data | input | 24 | FIFO word, right-aligned |
| tx_valid | input | 1 | FIFO has a word |
| tx_ready | output | 1 | Word taken this cycle when valid |
| bclk_i | input | 1 | External bit clock |
| sdata_o | output | 1 | Serial data |
| fsync_o | output | 1 | Frame sync |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The assertions check four rules on every cycle. Configuration stays frozen while enabled. Serial data is zero while disabled. The FIFO handshake is a lone pulse given only while enabled. The underrun flag stays set until the next enable. The bench runs scenarios that compare every serial bit and every frame-sync level against a model built from the requirements, across all four sync styles, both polarities, several slot counts and masks, and FIFO exhaustion. It also compares the number of words fetched and the underrun outcome after each run. Left alignment, the lead-in bit and the edge choice can only be seen in those scenarios.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the serial audio transmitter.
package tdm_tx_pkg;
    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_DSPA = 2'd2,
        FMT_DSPB = 2'd3
    } fmt_e;

    localparam int DATA_W = 24;

    // Word length in bits for a length code; code 3 acts as 24.
    function automatic logic [4:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd16;
            2'd1:    return 5'd20;
            default: return 5'd24;
        endcase
    endfunction
endpackage

// File: rtl/tdm_tx_bclk_edge.sv
`timescale 1ns/1ps
// Synchronises the external bit clock into the system clock domain and
// emits a one-cycle tick on the selected shifting edge.
// Assumes the system clock is at least six times the bit clock rate.
module tdm_tx_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic shift_on_rise,
    output logic tick
);
    logic s1, s2, s3;

    // Three-stage sampler: two for metastability, one for edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= bclk_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign tick = (s2 != s3) && (s2 == shift_on_rise);
endmodule

// File: rtl/tdm_tx_framer.sv
`timescale 1ns/1ps
// Tracks slot and bit position inside the frame, drives the frame-sync
// pin, and tells the shifter when to load, shift and fetch a word.
// Assumes configuration is static while en is high and SLOT_W >= 24.
module tdm_tx_framer
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         tick,
    input  fmt_e                         fmt,
    input  logic                         fs_inv,
    input  logic [$clog2(MAX_SLOTS)-1:0] slots_m1,
    input  logic [4:0]                   wl,
    input  logic [MAX_SLOTS-1:0]         mask,
    output logic                         adv,
    output logic                         load,
    output logic                         load_act,
    output logic                         pull,
    output logic                         fsync_o
);
    localparam int SC_W  = $clog2(MAX_SLOTS);
    localparam int BIT_W = $clog2(SLOT_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

    logic [SC_W-1:0]  slot_q, slot_n, slot_after;
    logic [BIT_W-1:0] bit_q, bit_n;
    logic             started_q;
    logic             fs_q;
    logic             long_sync, early_sync, fs_act, idle_lvl;
    int               sync_len;

    // Next bit position; before the first edge it is the lead-in bit.
    always_comb begin
        slot_n = slots_m1;
        bit_n  = LAST_BIT;
        if (started_q) begin
            slot_n = slot_q;
            bit_n  = bit_q + BIT_W'(1);
            if (bit_q == LAST_BIT) begin
                bit_n  = '0;
                slot_n = (slot_q == slots_m1) ? '0 : slot_q + SC_W'(1);
            end
        end
        slot_after = (slot_n == slots_m1) ? '0 : slot_n + SC_W'(1);
    end

    // Frame-sync shape for the next bit position.
    always_comb begin
        long_sync  = (fmt == FMT_I2S) || (fmt == FMT_LJ);
        early_sync = (fmt == FMT_I2S) || (fmt == FMT_DSPA);
        sync_len   = long_sync ? int'(wl) : 1;
        idle_lvl   = (fmt == FMT_I2S) ^ fs_inv;
        if (early_sync)
            fs_act = ((slot_n == slots_m1) && (bit_n == LAST_BIT)) ||
                     ((slot_n == '0) && (int'(bit_n) < sync_len - 1));
        else
            fs_act = (slot_n == '0) && (int'(bit_n) < sync_len);
    end

    assign adv      = tick && en;
    assign load     = adv && (bit_n == '0);
    assign load_act = mask[slot_n];
    assign pull     = adv && (bit_n == LAST_BIT) && mask[slot_after];
    assign fsync_o  = fs_q;

    // Position and frame-sync registers; parked while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= '0;
            bit_q     <= '0;
            started_q <= 1'b0;
            fs_q      <= 1'b1;
        end else if (!en) begin
            started_q <= 1'b0;
            fs_q      <= idle_lvl;
        end else if (tick) begin
            slot_q    <= slot_n;
            bit_q     <= bit_n;
            started_q <= 1'b1;
            fs_q      <= fs_act ^ idle_lvl;
        end
    end
endmodule

// File: rtl/tdm_tx_shifter.sv
`timescale 1ns/1ps
// Holds the fetched word, loads it at slot start and shifts it out MSB
// first; keeps the sticky underrun flag.
// Assumes SLOT_W >= DATA_W and that load and pull never coincide.
module tdm_tx_shifter
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              adv,
    input  logic              load,
    input  logic              load_act,
    input  logic              pull,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [4:0]        wl,
    output logic              sdata_o,
    output logic              underrun_o
);
    logic [DATA_W-1:0] word_mask;
    logic [SLOT_W-1:0] aligned, nxt_q, sh_q;
    logic              udr_q;

    // Trim the word to its length and left-align it in the slot.
    always_comb begin
        word_mask = DATA_W'((32'd1 << wl) - 32'd1);
        aligned   = SLOT_W'(tx_data & word_mask) << (SLOT_W - int'(wl));
    end

    // Fetch, load and shift; zero everything while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q <= '0;
            sh_q  <= '0;
            udr_q <= 1'b0;
        end else begin
            if (start)
                udr_q <= 1'b0;
            if (!en) begin
                nxt_q <= '0;
                sh_q  <= '0;
            end else begin
                if (pull) begin
                    nxt_q <= tx_valid ? aligned : '0;
                    if (!tx_valid)
                        udr_q <= 1'b1;
                end
                if (load)
                    sh_q <= load_act ? nxt_q : '0;
                else if (adv)
                    sh_q <= sh_q << 1;
            end
        end
    end

    assign sdata_o    = sh_q[SLOT_W-1];
    assign underrun_o = udr_q;
endmodule

// File: rtl/tdm_tx.sv
`timescale 1ns/1ps
// Top of the multi-slot serial audio transmitter: configuration
// registers (writable only while disabled) plus edge, framer and shifter.
// Assumes MAX_SLOTS is a power of two and SLOT_W >= 24.
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_fmt,
    input  logic                         cfg_bclk_inv,
    input  logic                         cfg_fs_inv,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots,
    input  logic [1:0]                   cfg_wlen,
    input  logic [MAX_SLOTS-1:0]         cfg_mask,
    input  logic [23:0]                  tx_data,
    input  logic                         tx_valid,
    output logic                         tx_ready,
    input  logic                         bclk_i,
    output logic                         sdata_o,
    output logic                         fsync_o,
    output logic                         underrun_o
);
    localparam int SC_W  = $clog2(MAX_SLOTS);
    localparam int CFG_W = 6 + SC_W + 2 + MAX_SLOTS - 2;

    fmt_e                 fmt_q;
    logic                 bclk_inv_q, fs_inv_q, en_q;
    logic [SC_W-1:0]      slots_q;
    logic [1:0]           wlen_q;
    logic [MAX_SLOTS-1:0] mask_q;
    logic [4:0]           wl;
    logic                 tick, adv, load, load_act, pull;
    logic [CFG_W-1:0]     cfg_bus;

    // Configuration registers, loaded only while the port is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q      <= FMT_I2S;
            bclk_inv_q <= 1'b0;
            fs_inv_q   <= 1'b0;
            slots_q    <= SC_W'(1);
            wlen_q     <= 2'd0;
            mask_q     <= '1;
        end else if (cfg_we && !en) begin
            fmt_q      <= fmt_e'(cfg_fmt);
            bclk_inv_q <= cfg_bclk_inv;
            fs_inv_q   <= cfg_fs_inv;
            slots_q    <= cfg_slots;
            wlen_q     <= cfg_wlen;
            mask_q     <= cfg_mask;
        end
    end

    // Enable history for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign wl       = wlen_bits(wlen_q);
    assign tx_ready = pull;
    assign cfg_bus  = {fmt_q, bclk_inv_q, fs_inv_q, slots_q, wlen_q, mask_q};

    tdm_tx_bclk_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i),
        .shift_on_rise(bclk_inv_q), .tick(tick)
    );

    tdm_tx_framer #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .fmt(fmt_q), .fs_inv(fs_inv_q), .slots_m1(slots_q), .wl(wl),
        .mask(mask_q), .adv(adv), .load(load), .load_act(load_act),
        .pull(pull), .fsync_o(fsync_o)
    );

    tdm_tx_shifter #(.SLOT_W(SLOT_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .en(en), .start(en && !en_q),
        .adv(adv), .load(load), .load_act(load_act), .pull(pull),
        .tx_valid(tx_valid), .tx_data(tx_data), .wl(wl),
        .sdata_o(sdata_o), .underrun_o(underrun_o)
    );
endmodule

// File: rtl/tdm_tx_chk.sv
`timescale 1ns/1ps
// Cycle-level rules of the transmitter, bound to every tdm_tx instance.
module tdm_tx_chk #(
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             en_q,
    input logic             tx_ready,
    input logic             sdata_o,
    input logic             underrun_o,
    input logic [CFG_W-1:0] cfg_bus
);
    // R7: configuration cannot change while the port is enabled
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg_bus));

    // R11: serial data is silent once the port is disabled
    a_r11_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sdata_o);

    // R9: a fetch is a lone one-cycle pulse
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    // R9: no fetch while disabled
    a_r9_ready_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> en);

    // R10: underrun stays set while the port keeps running
    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_o && en && en_q) |=> underrun_o);
endmodule

bind tdm_tx tdm_tx_chk #(.CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .en_q(en_q), .tx_ready(tx_ready),
    .sdata_o(sdata_o), .underrun_o(underrun_o), .cfg_bus(cfg_bus)
);

// File: tb/tb_tdm_tx.sv
`timescale 1ns/1ps
// Self-checking bench: directed and seeded random framing scenarios.
module tb_tdm_tx;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT_W     = 32;
    localparam int HALF       = 6;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst_n, en, cfg_we, cfg_bclk_inv, cfg_fs_inv, bclk;
    logic [1:0]  cfg_fmt, cfg_wlen;
    logic [2:0]  cfg_slots;
    logic [7:0]  cfg_mask;
    logic [23:0] tx_data;
    logic        tx_valid, tx_ready, sdata_o, fsync_o, underrun_o;

    logic [23:0] fifo_mem [0:63];
    int          idx = 0;
    int          nwords = 0;
    logic        take = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tx_valid = (idx < nwords);
    assign tx_data  = fifo_mem[6'(idx)];

    tdm_tx dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
        .cfg_fmt(cfg_fmt), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_fs_inv(cfg_fs_inv), .cfg_slots(cfg_slots),
        .cfg_wlen(cfg_wlen), .cfg_mask(cfg_mask), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .bclk_i(bclk),
        .sdata_o(sdata_o), .fsync_o(fsync_o), .underrun_o(underrun_o)
    );

    // FIFO model: a word seen taken at a posedge is popped at the next negedge.
    initial begin
        forever begin
            @(negedge clk);
            if (take) idx++;
            take = tx_ready && tx_valid;
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wl_of(input logic [1:0] c);
        return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
    endfunction

    // One bit period: shifting edge, settle, sample point, opposite edge.
    task automatic bit_step(input logic shift_lvl);
        bclk = shift_lvl;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_finish(input logic shift_lvl);
        bclk = ~shift_lvl;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_cfg(input logic [1:0] f, input logic bi, input logic fi,
                           input logic [2:0] sm, input logic [1:0] wc,
                           input logic [7:0] m, input int nw, input int frames);
        int frame_bits, wl, wcnt, pulls, fp, s, b, len, act_cnt;
        logic [23:0] cur;
        logic idle, early, exp_sd, exp_fs;
        en = 1'b0;
        repeat (4) @(negedge clk);
        bclk = ~bi;
        for (int i = 0; i < 64; i++) fifo_mem[i] = 24'($urandom);
        nwords = nw;
        idx = 0;
        cfg_fmt = f; cfg_bclk_inv = bi; cfg_fs_inv = fi;
        cfg_slots = sm; cfg_wlen = wc; cfg_mask = m;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (6) @(negedge clk);
        idle = (f == 2'd0) ^ fi;
        check("R5 R11", "idle fsync", int'(fsync_o), int'(idle));
        en = 1'b1;
        @(negedge clk);
        // R7: a write while enabled must be ignored
        cfg_fmt = f ^ 2'b01; cfg_fs_inv = ~fi; cfg_mask = ~m; cfg_slots = sm + 3'd1;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        wl = wl_of(wc);
        frame_bits = (int'(sm) + 1) * SLOT_W;
        early = (f == 2'd0) || (f == 2'd2);
        len = (f == 2'd0 || f == 2'd1) ? wl : 1;
        wcnt = 0;
        cur = '0;
        for (int k = 0; k <= frames * frame_bits; k++) begin
            fp = (k == 0) ? frame_bits - 1 : (k - 1) % frame_bits;
            s = fp / SLOT_W;
            b = fp % SLOT_W;
            if (k > 0 && b == 0) begin
                if (m[s]) begin
                    cur = (wcnt < nw) ? fifo_mem[wcnt] : 24'd0;
                    wcnt++;
                end else cur = '0;
            end
            exp_sd = (k > 0 && b < wl) ? cur[wl-1-b] : 1'b0;
            exp_fs = (early ? (fp == frame_bits - 1 || fp < len - 1) : (fp < len)) ^ idle;
            bit_step(bi);
            if (k == 0)
                check("R8", "lead-in sdata", int'(sdata_o), 0);
            else
                check("R1 R2 R3 R7 R10", "sdata", int'(sdata_o), int'(exp_sd));
            check("R4 R5 R6 R7", "fsync", int'(fsync_o), int'(exp_fs));
            bit_finish(bi);
        end
        repeat (4) @(negedge clk);
        act_cnt = 0;
        for (int i = 0; i <= int'(sm); i++) if (m[i]) act_cnt++;
        pulls = frames * act_cnt + int'(m[0]);
        check("R1 R2 R9", "words fetched", idx, (pulls < nw) ? pulls : nw);
        check("R10", "underrun flag", int'(underrun_o), int'(pulls > nw));
        en = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "disabled sdata", int'(sdata_o), 0);
        check("R11", "disabled ready", int'(tx_ready), 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        rst_n = 1'b0; en = 1'b0; cfg_we = 1'b0; bclk = 1'b1;
        cfg_fmt = 2'd0; cfg_bclk_inv = 1'b0; cfg_fs_inv = 1'b0;
        cfg_slots = 3'd1; cfg_wlen = 2'd0; cfg_mask = 8'hFF;
        for (int i = 0; i < 64; i++) fifo_mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "reset sdata", int'(sdata_o), 0);
        check("R11", "reset fsync", int'(fsync_o), 1);
        check("R11", "reset ready", int'(tx_ready), 0);
        check("R11", "reset underrun", int'(underrun_o), 0);
        // Directed: each sync style, polarities, slot counts and masks
        run_cfg(2'd0, 1'b0, 1'b0, 3'd1, 2'd0, 8'h03, 64, 2);
        run_cfg(2'd1, 1'b0, 1'b0, 3'd2, 2'd2, 8'h05, 64, 2);
        run_cfg(2'd2, 1'b1, 1'b0, 3'd3, 2'd1, 8'h0B, 64, 2);
        run_cfg(2'd3, 1'b0, 1'b1, 3'd0, 2'd3, 8'h01, 64, 3);
        // R10: FIFO runs dry, then the flag clears on the next enable
        run_cfg(2'd3, 1'b0, 1'b0, 3'd1, 2'd0, 8'h03, 2, 2);
        run_cfg(2'd2, 1'b0, 1'b0, 3'd1, 2'd2, 8'h03, 64, 2);
        // R2: slot 0 inactive, mask bits above the slot count set
        run_cfg(2'd0, 1'b1, 1'b1, 3'd1, 2'd1, 8'hFE, 64, 2);
        // Seeded random framings
        for (int r = 0; r < 4; r++) begin
            run_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                    3'($urandom % 4), 2'($urandom % 4), 8'($urandom),
                    int'($urandom % 12), 2);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule